// File: doc/BRIEF.md
# Two-Level Serial Interrupt Aggregator

This block gathers decoded serial-interrupt request levels, together with a handful of bus event strobes (link reset, sync errors, bus-master requests), into a first-level status register. That status is qualified by a mask register and by a global enable bit held in a control register. The qualified result drives a single line into a second-level stage, which has a read-only input register, a mask, a sticky latched status and a polarity register. Any bit left set in the second-level status raises one level-sensitive interrupt towards the system.

Both levels sit behind one 32-bit register port. The port takes a block-select bit and a byte offset. Only full-word (4-byte) accesses are honoured. Status bits in both stages are set by hardware and are only ever cleared by software, which writes ones to them. Status never drops when a request line falls. Read data is returned in the same cycle that the read request is presented.

Top module: `sirq_agg_top`

## Requirements
- R1: While serial line n (`sirq_lvl[n]`) is high at a clock edge, first-stage status bit (31 − n) is set after that edge. Line 0 maps to bit 31 and line 16 to bit 15. A low line never clears a status bit.
- R2: Event inputs set first-stage status bits and never clear them. `evt_lreset` sets bit 10. `evt_sync_err[k]` sets bit k+2, for k = 0..5. `evt_bm_req[1]` sets bit 1 and `evt_bm_req[0]` sets bit 0.
- R3: A write to first-stage status (block 0, offset 0x08) clears each bit written as one and leaves the others alone. A request line that is high in the same cycle keeps its bit set.
- R4: Writes to first-stage control (block 0, offset 0x00) and first-stage mask (block 0, offset 0x04) replace the whole word. The stored value reads back unchanged.
- R5: Second-stage input bit 11 (block 1, offset 0x00) is high exactly when control bit 31 is set and (status AND mask) of the first stage is non-zero. The input register is read-only, and writes to it have no effect.
- R6: Every cycle, second-stage status (block 1, offset 0x08) ORs in (input AND mask), where mask is block 1, offset 0x04. Its bits are sticky and are cleared only by writing ones. A cleared bit comes back at once if its input and mask bits are still both high.
- R7: `irq_o` is high exactly when second-stage status is non-zero. It changes in the first cycle after the edge at which the causing line, event or write is sampled.
- R8: The polarity register (block 1, offset 0x0C) stores any word and reads it back. It has no effect on `irq_o`.
- R9: Only `req_size` code 2 (4 bytes) is accepted. Codes 0, 1 and 3 (1, 2 and 8 bytes) leave every register unchanged on a write and return 0xFFFFFFFF on a read.
- R10: A read of an unimplemented offset returns 0xFFFFFFFF, and a write to one changes nothing.
- R11: After reset, every register of both stages reads zero and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sirq_lvl | input | NUM_SIRQ | Decoded serial-interrupt request levels, line n at index n |
| evt_lreset | input | 1 | Link reset event |
| evt_sync_err | input | 6 | Sync error events, index k sets status bit k+2 |
| evt_bm_req | input | 2 | Bus-master request events, index i sets status bit i |
| req_valid | input | 1 | Register access present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_blk | input | 1 | 0 = first stage, 1 = second stage |
| req_offset | input | OFF_W | Byte offset inside the selected stage |
| req_size | input | 2 | Access size code: 0 = 1 B, 1 = 2 B, 2 = 4 B, 3 = 8 B |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data for the current request, combinational |
| irq_o | output | 1 | System interrupt level |

## Verification
Some behaviour is checked by assertions on every cycle. A first-stage status bit, once set, survives every cycle without a status write. A sampled request line always sets its mapped bit. The second-stage input stays low while the global enable is off. A rising second-stage status bit is always backed by its mask and input bits. `irq_o` always tracks whether second-stage status is non-zero. Other behaviour only the bench scenarios can show, comparing against a reference model. These cover the exact bit mapping of each event input, the rule that a coincident set beats a clear, the re-latching of a cleared second-stage bit while its cause persists, and the polarity register having no effect. They also cover the all-ones reads for bad sizes and unimplemented offsets.

// File: rtl/sirq_agg_pkg.sv
package sirq_agg_pkg;

   localparam int WORD_W = 32;

   typedef enum logic [1:0] {
      ACC_1B = 2'd0,
      ACC_2B = 2'd1,
      ACC_4B = 2'd2,
      ACC_8B = 2'd3
   } acc_size_e;

   // byte offsets inside each stage
   localparam logic [7:0] HS_CTRL_OFF = 8'h00;
   localparam logic [7:0] HS_MASK_OFF = 8'h04;
   localparam logic [7:0] HS_STAT_OFF = 8'h08;
   localparam logic [7:0] MS_IN_OFF   = 8'h00;
   localparam logic [7:0] MS_MASK_OFF = 8'h04;
   localparam logic [7:0] MS_STAT_OFF = 8'h08;
   localparam logic [7:0] MS_POL_OFF  = 8'h0C;

   localparam logic [WORD_W-1:0] ALL_ONES = '1;

   typedef struct packed {
      logic              ctrl_we;
      logic              mask_we;
      logic              stat_we;
      logic [WORD_W-1:0] wdata;
   } host_wr_t;

   typedef struct packed {
      logic              mask_we;
      logic              stat_we;
      logic              pol_we;
      logic [WORD_W-1:0] wdata;
   } master_wr_t;

endpackage

// File: rtl/sirq_reg_port.sv
module sirq_reg_port
   import sirq_agg_pkg::*;
#(
   parameter int OFF_W = 8
) (
   input  logic              req_valid,
   input  logic              req_write,
   input  logic              req_blk,
   input  logic [OFF_W-1:0]  req_offset,
   input  logic [1:0]        req_size,
   input  logic [WORD_W-1:0] req_wdata,
   input  logic [WORD_W-1:0] hs_ctrl,
   input  logic [WORD_W-1:0] hs_mask,
   input  logic [WORD_W-1:0] hs_stat,
   input  logic [WORD_W-1:0] ms_in,
   input  logic [WORD_W-1:0] ms_mask,
   input  logic [WORD_W-1:0] ms_stat,
   input  logic [WORD_W-1:0] ms_pol,
   output host_wr_t          host_wr,
   output master_wr_t        master_wr,
   output logic [WORD_W-1:0] rd_data
);

   localparam int CMP_W = (OFF_W < 8) ? OFF_W : 8;

   logic size_ok;
   logic wr_ok;
   logic hi_zero;
   logic [7:0] off8;

   assign size_ok = (acc_size_e'(req_size) == ACC_4B);
   assign wr_ok   = req_valid & req_write & size_ok;

   generate
      if (OFF_W > 8) begin : g_wide_off
         assign hi_zero = (req_offset[OFF_W-1:8] == '0);
         assign off8    = req_offset[7:0];
      end else begin : g_narrow_off
         assign hi_zero = 1'b1;
         assign off8    = 8'(req_offset[CMP_W-1:0]);
      end
   endgenerate

   always_comb begin
      host_wr         = '0;
      master_wr       = '0;
      host_wr.wdata   = req_wdata;
      master_wr.wdata = req_wdata;
      if (wr_ok && hi_zero) begin
         if (!req_blk) begin
            host_wr.ctrl_we = (off8 == HS_CTRL_OFF);
            host_wr.mask_we = (off8 == HS_MASK_OFF);
            host_wr.stat_we = (off8 == HS_STAT_OFF);
         end else begin
            master_wr.mask_we = (off8 == MS_MASK_OFF);
            master_wr.stat_we = (off8 == MS_STAT_OFF);
            master_wr.pol_we  = (off8 == MS_POL_OFF);
         end
      end
   end

   always_comb begin
      rd_data = ALL_ONES;
      if (size_ok && hi_zero) begin
         if (!req_blk) begin
            case (off8)
               HS_CTRL_OFF: rd_data = hs_ctrl;
               HS_MASK_OFF: rd_data = hs_mask;
               HS_STAT_OFF: rd_data = hs_stat;
               default:     rd_data = ALL_ONES;
            endcase
         end else begin
            case (off8)
               MS_IN_OFF:   rd_data = ms_in;
               MS_MASK_OFF: rd_data = ms_mask;
               MS_STAT_OFF: rd_data = ms_stat;
               MS_POL_OFF:  rd_data = ms_pol;
               default:     rd_data = ALL_ONES;
            endcase
         end
      end
   end

endmodule

// File: rtl/sirq_host_stage.sv
module sirq_host_stage
   import sirq_agg_pkg::*;
#(
   parameter int NUM_SIRQ = 17,
   parameter int EN_BIT   = 31
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_SIRQ-1:0] sirq_lvl,
   input  logic                evt_lreset,
   input  logic [5:0]          evt_sync_err,
   input  logic [1:0]          evt_bm_req,
   input  host_wr_t            wr,
   output logic [WORD_W-1:0]   ctrl_q,
   output logic [WORD_W-1:0]   mask_q,
   output logic [WORD_W-1:0]   stat_q,
   output logic                hit_nxt
);

   localparam int TOP_BIT   = WORD_W - 1;
   localparam int LRESET_BIT = 10;

   logic [WORD_W-1:0] sirq_map;
   logic [WORD_W-1:0] evt_map;
   logic [WORD_W-1:0] set_vec;
   logic [WORD_W-1:0] ctrl_nxt;
   logic [WORD_W-1:0] mask_nxt;
   logic [WORD_W-1:0] stat_nxt;

   // line n lands on bit (31 - n)
   always_comb begin
      sirq_map = '0;
      for (int n = 0; n < NUM_SIRQ; n++) begin
         sirq_map[TOP_BIT-n] = sirq_lvl[n];
      end
   end

   always_comb begin
      evt_map             = '0;
      evt_map[LRESET_BIT] = evt_lreset;
      evt_map[7:2]        = evt_sync_err;
      evt_map[1:0]        = evt_bm_req;
   end

   assign set_vec  = sirq_map | evt_map;
   assign ctrl_nxt = wr.ctrl_we ? wr.wdata : ctrl_q;
   assign mask_nxt = wr.mask_we ? wr.wdata : mask_q;
   assign stat_nxt = (wr.stat_we ? (stat_q & ~wr.wdata) : stat_q) | set_vec;
   assign hit_nxt  = ctrl_nxt[EN_BIT] & (|(stat_nxt & mask_nxt));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         mask_q <= '0;
         stat_q <= '0;
      end else begin
         ctrl_q <= ctrl_nxt;
         mask_q <= mask_nxt;
         stat_q <= stat_nxt;
      end
   end

   // sampled request levels always leave their bits set
   assert_line_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (|set_vec) |=> ((stat_q & $past(set_vec)) == $past(set_vec)));

   // without a status write no bit can fall
   assert_stat_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !wr.stat_we |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

   // bits 9..8 have no source and stay clear
   assert_no_phantom_R2: assert property (@(posedge clk) disable iff (!rst_n)
      stat_q[9:8] == 2'b00);

endmodule

// File: rtl/sirq_master_stage.sv
module sirq_master_stage
   import sirq_agg_pkg::*;
#(
   parameter int LINE_BIT     = 11,
   parameter bit IRQ_OUT_FLOP = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hit_nxt,
   input  master_wr_t        wr,
   output logic [WORD_W-1:0] in_q,
   output logic [WORD_W-1:0] mask_q,
   output logic [WORD_W-1:0] stat_q,
   output logic [WORD_W-1:0] pol_q,
   output logic              irq_o
);

   logic [WORD_W-1:0] in_nxt;
   logic [WORD_W-1:0] mask_nxt;
   logic [WORD_W-1:0] stat_nxt;

   always_comb begin
      in_nxt           = '0;
      in_nxt[LINE_BIT] = hit_nxt;
   end

   assign mask_nxt = wr.mask_we ? wr.wdata : mask_q;
   assign stat_nxt = (wr.stat_we ? (stat_q & ~wr.wdata) : stat_q) | (in_nxt & mask_nxt);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         in_q   <= '0;
         mask_q <= '0;
         stat_q <= '0;
         pol_q  <= '0;
      end else begin
         in_q   <= in_nxt;
         mask_q <= mask_nxt;
         stat_q <= stat_nxt;
         if (wr.pol_we) pol_q <= wr.wdata;
      end
   end

   generate
      if (IRQ_OUT_FLOP) begin : g_irq_flop
         logic irq_q;
         always_ff @(posedge clk) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= |stat_nxt;
         end
         assign irq_o = irq_q;
      end else begin : g_irq_from_stat
         assign irq_o = |stat_q;
      end
   endgenerate

   assert_stat_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !wr.stat_we |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

   assert_rise_backed_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_q[LINE_BIT]) |-> (mask_q[LINE_BIT] && in_q[LINE_BIT]));

   assert_irq_tracks_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o == (stat_q != '0));

endmodule

// File: rtl/sirq_agg_top.sv
module sirq_agg_top
   import sirq_agg_pkg::*;
#(
   parameter int NUM_SIRQ     = 17,
   parameter int EN_BIT       = 31,
   parameter int LINE_BIT     = 11,
   parameter int OFF_W        = 8,
   parameter bit IRQ_OUT_FLOP = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_SIRQ-1:0] sirq_lvl,
   input  logic                evt_lreset,
   input  logic [5:0]          evt_sync_err,
   input  logic [1:0]          evt_bm_req,
   input  logic                req_valid,
   input  logic                req_write,
   input  logic                req_blk,
   input  logic [OFF_W-1:0]    req_offset,
   input  logic [1:0]          req_size,
   input  logic [31:0]         req_wdata,
   output logic [31:0]         rd_data,
   output logic                irq_o
);

   generate
      if (NUM_SIRQ < 1 || NUM_SIRQ > 17) begin : g_bad_nsirq
         $error("NUM_SIRQ must lie in 1..17");
      end
      if (EN_BIT < 0 || EN_BIT >= WORD_W) begin : g_bad_en
         $error("EN_BIT outside the register word");
      end
      if (LINE_BIT < 0 || LINE_BIT >= WORD_W) begin : g_bad_line
         $error("LINE_BIT outside the register word");
      end
      if (OFF_W < 4) begin : g_bad_off
         $error("OFF_W too narrow for the register map");
      end
   endgenerate

   host_wr_t          host_wr;
   master_wr_t        master_wr;
   logic [WORD_W-1:0] hs_ctrl, hs_mask, hs_stat;
   logic [WORD_W-1:0] ms_in, ms_mask, ms_stat, ms_pol;
   logic              hit_nxt;

   sirq_reg_port #(.OFF_W(OFF_W)) u_port (
      .req_valid  (req_valid),
      .req_write  (req_write),
      .req_blk    (req_blk),
      .req_offset (req_offset),
      .req_size   (req_size),
      .req_wdata  (req_wdata),
      .hs_ctrl    (hs_ctrl),
      .hs_mask    (hs_mask),
      .hs_stat    (hs_stat),
      .ms_in      (ms_in),
      .ms_mask    (ms_mask),
      .ms_stat    (ms_stat),
      .ms_pol     (ms_pol),
      .host_wr    (host_wr),
      .master_wr  (master_wr),
      .rd_data    (rd_data)
   );

   sirq_host_stage #(.NUM_SIRQ(NUM_SIRQ), .EN_BIT(EN_BIT)) u_host (
      .clk          (clk),
      .rst_n        (rst_n),
      .sirq_lvl     (sirq_lvl),
      .evt_lreset   (evt_lreset),
      .evt_sync_err (evt_sync_err),
      .evt_bm_req   (evt_bm_req),
      .wr           (host_wr),
      .ctrl_q       (hs_ctrl),
      .mask_q       (hs_mask),
      .stat_q       (hs_stat),
      .hit_nxt      (hit_nxt)
   );

   sirq_master_stage #(.LINE_BIT(LINE_BIT), .IRQ_OUT_FLOP(IRQ_OUT_FLOP)) u_master (
      .clk     (clk),
      .rst_n   (rst_n),
      .hit_nxt (hit_nxt),
      .wr      (master_wr),
      .in_q    (ms_in),
      .mask_q  (ms_mask),
      .stat_q  (ms_stat),
      .pol_q   (ms_pol),
      .irq_o   (irq_o)
   );

   // global enable off keeps the link between stages quiet
   assert_enable_gates_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !hs_ctrl[EN_BIT] |-> !ms_in[LINE_BIT]);

   // link is high only with a masked first-stage cause present
   assert_link_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ms_in[LINE_BIT] |-> ((hs_stat & hs_mask) != '0));

endmodule

// File: tb/sirq_agg_top_tb.sv
`timescale 1ns/1ps
module sirq_agg_top_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [16:0] sirq_lvl = '0;
   logic        evt_lreset = 1'b0;
   logic [5:0]  evt_sync_err = '0;
   logic [1:0]  evt_bm_req = '0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic        req_blk = 1'b0;
   logic [7:0]  req_offset = '0;
   logic [1:0]  req_size = 2'd2;
   logic [31:0] req_wdata = '0;
   logic [31:0] rd_data;
   logic        irq_o;

   int n_checks = 0;
   int n_fails  = 0;
   bit finished = 1'b0;

   // reference model state
   logic [31:0] h_ctrl, h_mask, h_stat, m_in, m_mask, m_stat, m_pol;
   logic        m_irq;

   always #2 clk = ~clk;

   sirq_agg_top u_dut (
      .clk(clk), .rst_n(rst_n), .sirq_lvl(sirq_lvl), .evt_lreset(evt_lreset),
      .evt_sync_err(evt_sync_err), .evt_bm_req(evt_bm_req), .req_valid(req_valid),
      .req_write(req_write), .req_blk(req_blk), .req_offset(req_offset),
      .req_size(req_size), .req_wdata(req_wdata), .rd_data(rd_data), .irq_o(irq_o)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: actual %08h expected %08h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [31:0] model_read(input logic blk, input logic [7:0] off,
                                              input logic [1:0] sz);
      if (sz != 2'd2) return 32'hFFFF_FFFF;
      if (!blk) begin
         case (off)
            8'h00: return h_ctrl;
            8'h04: return h_mask;
            8'h08: return h_stat;
            default: return 32'hFFFF_FFFF;
         endcase
      end
      case (off)
         8'h00: return m_in;
         8'h04: return m_mask;
         8'h08: return m_stat;
         8'h0C: return m_pol;
         default: return 32'hFFFF_FFFF;
      endcase
   endfunction

   task automatic model_step(input logic vld, input logic wr, input logic blk,
                             input logic [7:0] off, input logic [1:0] sz,
                             input logic [31:0] wd, input logic [16:0] sl,
                             input logic lr, input logic [5:0] se, input logic [1:0] bm);
      logic [31:0] setv;
      logic ok;
      setv = '0;
      for (int n = 0; n < 17; n++) if (sl[n]) setv[31-n] = 1'b1;
      setv[10] = lr;
      setv[7:2] = se;
      setv[1:0] = bm;
      ok = vld && wr && (sz == 2'd2);
      if (ok && !blk) begin
         if (off == 8'h00) h_ctrl = wd;
         if (off == 8'h04) h_mask = wd;
         if (off == 8'h08) h_stat = h_stat & ~wd;
      end
      h_stat = h_stat | setv;
      if (ok && blk) begin
         if (off == 8'h04) m_mask = wd;
         if (off == 8'h08) m_stat = m_stat & ~wd;
         if (off == 8'h0C) m_pol = wd;
      end
      m_in = (h_ctrl[31] && ((h_stat & h_mask) != 0)) ? 32'h0000_0800 : 32'h0;
      m_stat = m_stat | (m_in & m_mask);
      m_irq = (m_stat != 0);
   endtask

   // one clock of stimulus; called at a falling edge, returns at the next one
   task automatic step(input string tag, input logic vld, input logic wr, input logic blk,
                       input logic [7:0] off, input logic [1:0] sz, input logic [31:0] wd,
                       input logic [16:0] sl, input logic lr, input logic [5:0] se,
                       input logic [1:0] bm);
      req_valid = vld; req_write = wr; req_blk = blk; req_offset = off;
      req_size = sz; req_wdata = wd; sirq_lvl = sl; evt_lreset = lr;
      evt_sync_err = se; evt_bm_req = bm;
      #1;
      if (vld && !wr) check({tag, " read"}, rd_data, model_read(blk, off, sz));
      model_step(vld, wr, blk, off, sz, wd, sl, lr, se, bm);
      @(posedge clk);
      @(negedge clk);
      check({tag, " irq"}, {31'b0, irq_o}, {31'b0, m_irq});
   endtask

   task automatic wr32(input string tag, input logic blk, input logic [7:0] off,
                       input logic [31:0] wd);
      step(tag, 1, 1, blk, off, 2'd2, wd, '0, 0, '0, '0);
   endtask

   task automatic rd32(input string tag, input logic blk, input logic [7:0] off);
      step(tag, 1, 0, blk, off, 2'd2, '0, '0, 0, '0, '0);
   endtask

   task automatic idle(input string tag);
      step(tag, 0, 0, 0, 8'h00, 2'd2, '0, '0, 0, '0, '0);
   endtask

   initial begin
      #(200000 * 4);
      if (!finished) begin
         n_fails++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      h_ctrl = '0; h_mask = '0; h_stat = '0; m_in = '0; m_mask = '0; m_stat = '0;
      m_pol = '0; m_irq = 1'b0;
      void'($urandom(32'd1234));
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R11: reset state
      check("R11 irq after reset", {31'b0, irq_o}, 32'h0);
      rd32("R11 ctrl", 0, 8'h00);
      rd32("R11 mask", 0, 8'h04);
      rd32("R11 stat", 0, 8'h08);
      rd32("R11 m_in", 1, 8'h00);
      rd32("R11 m_mask", 1, 8'h04);
      rd32("R11 m_stat", 1, 8'h08);
      rd32("R11 m_pol", 1, 8'h0C);

      // R4: whole-word replace
      wr32("R4 mask write", 0, 8'h04, 32'hFFFF_FFFF);
      rd32("R4 mask read", 0, 8'h04);
      check("R4 mask value", rd_data, 32'hFFFF_FFFF);

      // R1: line 0 and line 16 positions, enable still off (R5)
      step("R1 line0", 0, 0, 0, 8'h00, 2'd2, '0, 17'h00001, 0, '0, '0);
      step("R1 line16", 0, 0, 0, 8'h00, 2'd2, '0, 17'h10000, 0, '0, '0);
      rd32("R1 stat", 0, 8'h08);
      check("R1 bits 31 and 15", rd_data, 32'h8000_8000);
      rd32("R5 input low while disabled", 1, 8'h00);
      check("R5 input value", rd_data, 32'h0);

      // R5/R7: enable, then second-stage mask
      wr32("R5 enable", 0, 8'h00, 32'h8000_0000);
      rd32("R5 input high", 1, 8'h00);
      check("R5 input bit11", rd_data, 32'h0000_0800);
      check("R7 irq low without mask", {31'b0, irq_o}, 32'h0);
      wr32("R7 master mask", 1, 8'h04, 32'h0000_0800);
      check("R7 irq one cycle after mask", {31'b0, irq_o}, 32'h1);

      // R5: input register is read-only
      wr32("R5 input write", 1, 8'h00, 32'h0000_0000);
      rd32("R5 input kept", 1, 8'h00);
      check("R5 input after write", rd_data, 32'h0000_0800);

      // R8: polarity has no effect
      wr32("R8 pol write", 1, 8'h0C, 32'hFFFF_FFFF);
      rd32("R8 pol read", 1, 8'h0C);
      check("R8 pol value", rd_data, 32'hFFFF_FFFF);
      check("R8 irq unchanged", {31'b0, irq_o}, 32'h1);

      // R6: master clear while cause persists re-latches
      wr32("R6 clear with cause", 1, 8'h08, 32'hFFFF_FFFF);
      check("R6 relatch", {31'b0, irq_o}, 32'h1);

      // R3: set beats clear in the same cycle
      step("R3 clear vs set", 1, 1, 0, 8'h08, 2'd2, 32'hFFFF_FFFF, 17'h00001, 0, '0, '0);
      rd32("R3 stat", 0, 8'h08);
      check("R3 bit31 kept", rd_data, 32'h8000_0000);
      wr32("R3 clear all", 0, 8'h08, 32'hFFFF_FFFF);
      rd32("R3 stat cleared", 0, 8'h08);
      check("R3 stat zero", rd_data, 32'h0);
      check("R6 master sticky", {31'b0, irq_o}, 32'h1);
      wr32("R6 clear master", 1, 8'h08, 32'h0000_0800);
      check("R6 irq drops", {31'b0, irq_o}, 32'h0);

      // R2: event bit positions
      step("R2 lreset", 0, 0, 0, 8'h00, 2'd2, '0, '0, 1, '0, '0);
      rd32("R2 stat", 0, 8'h08);
      check("R2 lreset bit10", rd_data, 32'h0000_0400);
      wr32("R2 clr", 0, 8'h08, 32'hFFFF_FFFF);
      wr32("R2 clr m", 1, 8'h08, 32'hFFFF_FFFF);
      for (int k = 0; k < 6; k++) begin
         step("R2 sync", 0, 0, 0, 8'h00, 2'd2, '0, '0, 0, 6'(1 << k), '0);
         rd32("R2 sync stat", 0, 8'h08);
         check("R2 sync bit", rd_data, 32'(1) << (k + 2));
         wr32("R2 clr", 0, 8'h08, 32'hFFFF_FFFF);
         wr32("R2 clr m", 1, 8'h08, 32'hFFFF_FFFF);
      end
      step("R2 bm", 0, 0, 0, 8'h00, 2'd2, '0, '0, 0, '0, 2'b10);
      rd32("R2 bm stat", 0, 8'h08);
      check("R2 bm bit1", rd_data, 32'h0000_0002);
      wr32("R2 clr", 0, 8'h08, 32'hFFFF_FFFF);
      wr32("R2 clr m", 1, 8'h08, 32'hFFFF_FFFF);

      // R9: bad sizes
      step("R9 1B write", 1, 1, 0, 8'h04, 2'd0, 32'h0, '0, 0, '0, '0);
      step("R9 8B write", 1, 1, 0, 8'h04, 2'd3, 32'h0, '0, 0, '0, '0);
      rd32("R9 mask kept", 0, 8'h04);
      check("R9 mask value", rd_data, 32'hFFFF_FFFF);
      step("R9 2B read", 1, 0, 1, 8'h04, 2'd1, '0, '0, 0, '0, '0);

      // R10: unimplemented offsets
      wr32("R10 write hole", 0, 8'h10, 32'h0);
      rd32("R10 read hole", 0, 8'h10);
      check("R10 ones", rd_data, 32'hFFFF_FFFF);
      rd32("R10 read hole m", 1, 8'h20);
      rd32("R10 ctrl intact", 0, 8'h00);

      // random mix against the model: R1 R2 R3 R4 R5 R6 R7 R8
      for (int i = 0; i < 4000; i++) begin
         logic [31:0] r;
         logic [7:0]  off;
         logic [16:0] sl;
         r   = $urandom;
         off = {4'h0, 2'(r[3:2]), 2'b00};
         if (r[4]) off = 8'h14;
         sl  = 17'($urandom & $urandom & $urandom & $urandom);
         step("R6 random", r[5] | r[6], r[7], r[8], off,
              (r[11:9] == 0) ? 2'(r[13:12]) : 2'd2,
              r[14] ? 32'hFFFF_FFFF : $urandom, sl,
              (r[19:15] == 0), 6'($urandom & $urandom & $urandom), 2'(r[21:20] & r[23:22]));
         if (r[31:28] == 0) idle("R7 idle");
      end

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end

endmodule